// File: doc/BRIEF.md
# Debug Session Arm and Breakpoint Controller

This block holds the control word of an on-chip debug unit and runs one debug session. Software arms the unit through a single register write. A four-state sequencer (disarmed, State1, intermediate, Final) then advances on two comparator-match inputs. A software trigger write can force the Final event at any time. When Final is reached, the block either hands off to an external trace engine and waits for it, or raises a breakpoint at once. The breakpoint is routed to a background-debug halt request or to a software interrupt.

The comparators, the trace buffer and the CPU halt logic sit outside. They connect through match, trace start/done and request pins. Bank-select bits choose which comparator bank is visible in the debug register window, and the block drives a one-hot window select for it. Control word layout: bit 7 arm, bit 6 trigger, bit 4 debug-mode select, bit 3 breakpoint enable, bits 1:0 bank select. All other bits read as 0.

Top module: `dbg_session_ctl`

## Requirements
- R1: After asynchronous reset the unit is disarmed, the sequencer code is 0, `reg_rdata_o` is 0, no pulse output is high and `win_sel_o` is 3'b001.
- R2: A write with bit 7 = 1 and bit 6 = 0 while disarmed sets `armed_o` and moves the sequencer to code 1 (State1). A write with bits 7 and 6 both 0 disarms, returns to code 0 and drops any pending trace wait or breakpoint.
- R3: In code 1, `match_a_i` moves the sequencer to code 2. In code 2, `match_b_i` produces the Final event.
- R4: A Final event with tracing off (`trace_src_en_i` = 0 or `secure_i` = 1) clears `armed_o` and returns to code 0 in the same cycle. If bit 3 is set, it also raises a one-cycle breakpoint pulse in that cycle.
- R5: A Final event with tracing on pulses `trace_start_o` for one cycle, enters code 3 and keeps `armed_o` as it was. On `trace_done_i` the session ends: a breakpoint pulse if bit 3 was set at the Final event, then arm clears and the code returns to 0.
- R6: A write with bit 6 = 1 and bit 7 = 0 produces the Final event whatever the sequencer code is, and leaves `armed_o` unchanged. Bit 6 always reads back 0.
- R7: While the block waits for a trace with `trace_begin_align_i` = 1, a trigger write has no effect.
- R8: While `secure_i` is 1, `trace_start_o` never pulses.
- R9: A write with bits 7 and 6 both 1 ends the session: disarmed, code 0, no breakpoint, no trace start, and a later `trace_done_i` is ignored.
- R10: A breakpoint pulses `bdm_req_o` when bit 4 is set and `bdm_enable_i` is 1. Otherwise it pulses `swi_req_o`. The two never pulse together.
- R11: Bank code 00, 01, 10 and 11 gives `win_sel_o` 001, 010, 100 and 000. `reg_rdata_o` returns arm, bit 4, bit 3 and the bank code at their write positions.
- R12: With bit 3 clear, a session still completes and clears arm, but no breakpoint pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | DATA_W | Control word write data |
| reg_rdata_o | output | DATA_W | Control word readback |
| match_a_i | input | 1 | Comparator match advancing State1 |
| match_b_i | input | 1 | Comparator match reaching Final |
| trace_src_en_i | input | 1 | Trace source enable |
| trace_begin_align_i | input | 1 | Trace begins at trigger (1) or ends at it (0) |
| secure_i | input | 1 | Secure mode, disables tracing |
| bdm_enable_i | input | 1 | Background debug available |
| trace_start_o | output | 1 | One-cycle trace start pulse |
| trace_done_i | input | 1 | Trace session complete |
| bdm_req_o | output | 1 | Breakpoint to background debug |
| swi_req_o | output | 1 | Breakpoint to software interrupt |
| armed_o | output | 1 | Arm bit |
| seq_state_o | output | 2 | Sequencer code 0..3 |
| win_sel_o | output | NUM_BANKS | One-hot comparator bank window select |

## Verification
A corrupted sequencer code appears on `seq_state_o` on the clock edge after it goes wrong. It also sends the next match or trace-done to the wrong place, so a missing or extra `trace_start_o`, `bdm_req_o` or `swi_req_o` pulse follows within one cycle of that stimulus. A lost pending-breakpoint flag stays hidden until `trace_done_i` arrives, and then shows up as a missing breakpoint pulse on that same edge. Arm-bit errors are visible at once on `armed_o` and on bit 7 of the readback. That is why the bench compares every output against its model on every cycle.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ONE   = 2'd1,
    SEQ_MID   = 2'd2,
    SEQ_FINAL = 2'd3
  } seq_state_e;

  localparam int unsigned ARM_BIT  = 7;
  localparam int unsigned TRIG_BIT = 6;
  localparam int unsigned BDM_BIT  = 4;
  localparam int unsigned BRK_BIT  = 3;

  typedef struct packed {
    logic end_ses;
    logic trig;
    logic arm_set;
    logic disarm;
  } wr_cmd_t;
endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned NUM_BANKS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 clear_arm_i,
  output wr_cmd_t              cmd_o,
  output logic                 brk_en_nxt_o,
  output logic                 bdm_sel_nxt_o,
  output logic                 arm_o,
  output logic                 bdm_sel_o,
  output logic                 brk_en_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [NUM_BANKS-1:0] win_sel_o
);
  logic w_arm, w_trig;
  logic [BANK_W-1:0]    bank_nxt;
  logic [NUM_BANKS-1:0] win_nxt;

  assign w_arm  = wdata_i[ARM_BIT];
  assign w_trig = wdata_i[TRIG_BIT];

  assign cmd_o.end_ses = we_i & w_arm & w_trig;
  assign cmd_o.trig    = we_i & ~w_arm & w_trig;
  assign cmd_o.arm_set = we_i & w_arm & ~w_trig & ~arm_o;
  assign cmd_o.disarm  = we_i & ~w_arm & ~w_trig;

  assign brk_en_nxt_o  = we_i ? wdata_i[BRK_BIT] : brk_en_o;
  assign bdm_sel_nxt_o = we_i ? wdata_i[BDM_BIT] : bdm_sel_o;
  assign bank_nxt      = we_i ? wdata_i[BANK_W-1:0] : bank_o;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_win
    assign win_nxt[g] = (bank_nxt == BANK_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_o     <= 1'b0;
      bdm_sel_o <= 1'b0;
      brk_en_o  <= 1'b0;
      bank_o    <= '0;
      win_sel_o <= NUM_BANKS'(1);
    end else begin
      bdm_sel_o <= bdm_sel_nxt_o;
      brk_en_o  <= brk_en_nxt_o;
      bank_o    <= bank_nxt;
      win_sel_o <= win_nxt;
      if (cmd_o.end_ses || cmd_o.disarm) arm_o <= 1'b0;
      else if (cmd_o.arm_set)            arm_o <= 1'b1;
      else if (clear_arm_i)              arm_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wr_cmd_t    cmd_i,
  input  logic       match_a_i,
  input  logic       match_b_i,
  input  logic       tracing_i,
  input  logic       begin_align_i,
  input  logic       brk_en_nxt_i,
  input  logic       trace_done_i,
  output seq_state_e state_o,
  output logic       trace_start_o,
  output logic       fire_o,
  output logic       clear_arm_o
);
  seq_state_e state_n;
  logic wait_q, wait_n, pend_q, pend_n, start_n;
  logic trig_acc, final_evt;

  // begin-aligned trace in flight locks out further triggers
  assign trig_acc  = cmd_i.trig & ~(wait_q & begin_align_i);
  assign final_evt = trig_acc | ((state_o == SEQ_MID) & match_b_i);

  always_comb begin
    state_n     = state_o;
    wait_n      = wait_q;
    pend_n      = pend_q;
    start_n     = 1'b0;
    fire_o      = 1'b0;
    clear_arm_o = 1'b0;
    if (cmd_i.end_ses || cmd_i.disarm) begin
      state_n = SEQ_IDLE;
      wait_n  = 1'b0;
      pend_n  = 1'b0;
    end else if (cmd_i.arm_set) begin
      state_n = SEQ_ONE;
      wait_n  = 1'b0;
      pend_n  = 1'b0;
    end else if (final_evt) begin
      if (tracing_i) begin
        state_n = SEQ_FINAL;
        wait_n  = 1'b1;
        pend_n  = brk_en_nxt_i;
        start_n = 1'b1;
      end else begin
        state_n     = SEQ_IDLE;
        wait_n      = 1'b0;
        pend_n      = 1'b0;
        fire_o      = brk_en_nxt_i;
        clear_arm_o = 1'b1;
      end
    end else if (wait_q && trace_done_i) begin
      state_n     = SEQ_IDLE;
      wait_n      = 1'b0;
      pend_n      = 1'b0;
      fire_o      = pend_q;
      clear_arm_o = 1'b1;
    end else if (state_o == SEQ_ONE && match_a_i) begin
      state_n = SEQ_MID;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o       <= SEQ_IDLE;
      wait_q        <= 1'b0;
      pend_q        <= 1'b0;
      trace_start_o <= 1'b0;
    end else begin
      state_o       <= state_n;
      wait_q        <= wait_n;
      pend_q        <= pend_n;
      trace_start_o <= start_n;
    end
  end
endmodule

// File: rtl/dbg_brk_route.sv
module dbg_brk_route (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic bdm_sel_i,
  input  logic bdm_enable_i,
  output logic bdm_req_o,
  output logic swi_req_o
);
  logic to_bdm;
  assign to_bdm = bdm_sel_i & bdm_enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bdm_req_o <= 1'b0;
      swi_req_o <= 1'b0;
    end else begin
      bdm_req_o <= fire_i & to_bdm;
      swi_req_o <= fire_i & ~to_bdm;
    end
  end
endmodule

// File: rtl/dbg_session_ctl.sv
module dbg_session_ctl
  import dbg_ctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned NUM_BANKS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic                 match_a_i,
  input  logic                 match_b_i,
  input  logic                 trace_src_en_i,
  input  logic                 trace_begin_align_i,
  input  logic                 secure_i,
  input  logic                 bdm_enable_i,
  output logic                 trace_start_o,
  input  logic                 trace_done_i,
  output logic                 bdm_req_o,
  output logic                 swi_req_o,
  output logic                 armed_o,
  output logic [1:0]           seq_state_o,
  output logic [NUM_BANKS-1:0] win_sel_o
);
  wr_cmd_t           cmd;
  seq_state_e        state;
  logic              brk_en_nxt, bdm_sel_nxt, bdm_sel, brk_en;
  logic              fire, clear_arm, tracing;
  logic [BANK_W-1:0] bank;

  assign tracing = trace_src_en_i & ~secure_i;

  dbg_ctl_regs #(.DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) i_regs (
    .clk_i, .rst_ni,
    .we_i          (reg_we_i),
    .wdata_i       (reg_wdata_i),
    .clear_arm_i   (clear_arm),
    .cmd_o         (cmd),
    .brk_en_nxt_o  (brk_en_nxt),
    .bdm_sel_nxt_o (bdm_sel_nxt),
    .arm_o         (armed_o),
    .bdm_sel_o     (bdm_sel),
    .brk_en_o      (brk_en),
    .bank_o        (bank),
    .win_sel_o     (win_sel_o)
  );

  dbg_seq i_seq (
    .clk_i, .rst_ni,
    .cmd_i         (cmd),
    .match_a_i, .match_b_i,
    .tracing_i     (tracing),
    .begin_align_i (trace_begin_align_i),
    .brk_en_nxt_i  (brk_en_nxt),
    .trace_done_i,
    .state_o       (state),
    .trace_start_o,
    .fire_o        (fire),
    .clear_arm_o   (clear_arm)
  );

  dbg_brk_route i_route (
    .clk_i, .rst_ni,
    .fire_i        (fire),
    .bdm_sel_i     (bdm_sel_nxt),
    .bdm_enable_i,
    .bdm_req_o, .swi_req_o
  );

  assign seq_state_o = state;

  always_comb begin
    reg_rdata_o                = '0;
    reg_rdata_o[ARM_BIT]       = armed_o;
    reg_rdata_o[BDM_BIT]       = bdm_sel;
    reg_rdata_o[BRK_BIT]       = brk_en;
    reg_rdata_o[BANK_W-1:0]    = bank;
  end
endmodule

// File: rtl/dbg_session_ctl_chk.sv
module dbg_session_ctl_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BANKS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic                 secure_i,
  input logic                 trace_start_o,
  input logic                 bdm_req_o,
  input logic                 swi_req_o,
  input logic                 armed_o,
  input logic [1:0]           seq_state_o,
  input logic [NUM_BANKS-1:0] win_sel_o
);
  // R10
  no_dual_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bdm_req_o, swi_req_o}));

  // R8
  no_secure_trace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_start_o |-> !$past(secure_i));

  // R4
  brk_ends_session_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bdm_req_o || swi_req_o) |-> (!armed_o && seq_state_o == 2'd0));

  // R5
  trace_in_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_start_o |-> seq_state_o == 2'd3);

  // R9
  end_write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[7] && reg_wdata_i[6]) |=>
      (!armed_o && seq_state_o == 2'd0 && !trace_start_o && !bdm_req_o && !swi_req_o));

  // R2
  arm_enters_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[7] && !reg_wdata_i[6] && !armed_o) |=>
      (armed_o && seq_state_o == 2'd1));

  // R11
  win_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_sel_o));
endmodule

bind dbg_session_ctl dbg_session_ctl_chk #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) i_chk (.*);

// File: tb/test_dbg_session_ctl.sv
module test_dbg_session_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 5000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic       ma = 1'b0, mb = 1'b0, src_en = 1'b0, balign = 1'b0, sec = 1'b0, bdm_en = 1'b0, tdone = 1'b0;
  logic [7:0] rdata;
  logic       tstart, bdm_req, swi_req, armed;
  logic [1:0] st;
  logic [2:0] win;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_session_ctl i_dbg_session_ctl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .match_a_i(ma), .match_b_i(mb), .trace_src_en_i(src_en), .trace_begin_align_i(balign),
    .secure_i(sec), .bdm_enable_i(bdm_en), .trace_start_o(tstart), .trace_done_i(tdone),
    .bdm_req_o(bdm_req), .swi_req_o(swi_req), .armed_o(armed), .seq_state_o(st), .win_sel_o(win)
  );

  // behavioural reference model
  bit m_arm, m_bdm, m_brk, m_wait, m_pend, m_ts, m_breq, m_sreq;
  int m_bank, m_st;

  task automatic breakpoint(input bit en);
    if (en) begin
      if (m_bdm && bdm_en) m_breq = 1; else m_sreq = 1;
    end
    m_arm = 0; m_st = 0; m_wait = 0; m_pend = 0;
  endtask

  task automatic reach_final();
    if (src_en && !sec) begin
      m_st = 3; m_wait = 1; m_pend = m_brk; m_ts = 1;
    end else breakpoint(m_brk);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arm = 0; m_bdm = 0; m_brk = 0; m_wait = 0; m_pend = 0;
      m_ts = 0; m_breq = 0; m_sreq = 0; m_bank = 0; m_st = 0;
    end else begin
      bit was_armed;
      bit wa, wt;
      was_armed = m_arm;
      m_ts = 0; m_breq = 0; m_sreq = 0;
      wa = we && wdata[7];
      wt = we && wdata[6];
      if (we) begin
        m_bdm = wdata[4]; m_brk = wdata[3]; m_bank = int'(wdata[1:0]);
      end
      if (we && (wa == wt)) begin
        m_arm = 0; m_st = 0; m_wait = 0; m_pend = 0;
      end else if (wa && !was_armed) begin
        m_arm = 1; m_st = 1; m_wait = 0; m_pend = 0;
      end else if (wt && !(m_wait && balign)) begin
        reach_final();
      end else if (m_st == 2 && mb) begin
        reach_final();
      end else if (m_wait && tdone) begin
        breakpoint(m_pend);
      end else if (m_st == 1 && ma) begin
        m_st = 2;
      end
    end
  end

  function automatic logic [2:0] exp_win();
    case (m_bank)
      0: return 3'b001;
      1: return 3'b010;
      2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R2 armed", armed, m_arm);
      check("R3 state", st, m_st);
      check("R5 trace_start", tstart, m_ts);
      check("R10 bdm_req", bdm_req, m_breq);
      check("R10 swi_req", swi_req, m_sreq);
      check("R11 win_sel", win, exp_win());
      check("R11 rdata", rdata, {m_arm, 2'b00, m_bdm, m_brk, 1'b0, 2'(m_bank)});
    end
    if (cyc > MAX_CYC) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, MAX_CYC);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] d);
    we = 1; wdata = d; tick(); we = 0;
  endtask

  task automatic pulse_a(); ma = 1; tick(); ma = 0; endtask
  task automatic pulse_b(); mb = 1; tick(); mb = 0; endtask
  task automatic pulse_done(); tdone = 1; tick(); tdone = 0; endtask

  initial begin
    repeat (2) tick();
    // R1 reset state
    check("R1 rdata", rdata, 0);
    check("R1 state", st, 0);
    check("R1 win", win, 3'b001);
    check("R1 pulses", {tstart, bdm_req, swi_req}, 0);
    rst_n = 1; tick();

    // R11 bank select
    wr(8'h01); check("R11 bank01", win, 3'b010);
    wr(8'h02); check("R11 bank10", win, 3'b100);
    wr(8'h03); check("R11 bank11", win, 3'b000);
    check("R11 readback", rdata, 8'h03);

    // R3 R4 R10 no tracing, break to bdm
    bdm_en = 1;
    wr(8'h98); check("R2 arm", {armed, st}, 3'b101);
    pulse_a(); check("R3 mid", st, 2);
    pulse_b(); check("R4 bdm pulse", {bdm_req, swi_req, armed, st}, 5'b10000);
    tick(); check("R4 single pulse", bdm_req, 0);

    // R5 R7 begin-aligned trace, trigger ignored
    src_en = 1; balign = 1;
    wr(8'h88); pulse_a(); pulse_b();
    check("R5 start", {tstart, armed, st}, 4'b1111);
    tick(); check("R5 start once", tstart, 0);
    wr(8'h48); check("R7 ignored", {tstart, swi_req, st}, 4'b0011);
    tick(); pulse_done();
    check("R5 done brk", {swi_req, bdm_req, armed, st}, 5'b10000);

    // R6 forced trigger while disarmed, no trace
    src_en = 0; tick();
    wr(8'h48); check("R6 forced", {swi_req, armed, st}, 4'b1000);
    check("R6 trig reads 0", rdata[6], 0);

    // R8 secure blocks trace
    src_en = 1; sec = 1;
    wr(8'h48); check("R8 no trace", {tstart, swi_req}, 2'b01);
    sec = 0;

    // R9 end session while awaiting trace
    wr(8'h88); pulse_a(); pulse_b(); check("R9 waiting", st, 3);
    wr(8'hC8); check("R9 end", {armed, st, tstart, swi_req, bdm_req}, 0);
    pulse_done(); check("R9 done ignored", {swi_req, bdm_req}, 0);

    // R10 software-interrupt fallback
    src_en = 0; bdm_en = 0;
    wr(8'h98); pulse_a(); pulse_b();
    check("R10 swi fallback", {bdm_req, swi_req}, 2'b01);

    // R12 breakpoint disabled
    wr(8'h80); pulse_a(); pulse_b();
    check("R12 no brk", {bdm_req, swi_req, armed, st}, 0);

    // R2 disarm mid-sequence
    wr(8'h80); pulse_a(); check("R2 mid", st, 2);
    wr(8'h00); check("R2 disarm", {armed, st}, 0);
    pulse_b(); check("R2 match after disarm", {st, swi_req}, 0);

    // R5 R6 forced trigger, end-aligned trace, arm unchanged
    src_en = 1; balign = 0; bdm_en = 1;
    wr(8'h58); check("R6 trace trig", {tstart, armed, st}, 4'b1011);
    wr(8'h58); check("R7 end-aligned retrigger", tstart, 1);
    pulse_done(); check("R10 bdm route", {bdm_req, swi_req}, 2'b10);

    repeat (3) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule